// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital sequencer for one H-bridge that holds winding current near a trip level by chopping. While enabled, it turns on the diagonal switch pair picked by the direction input and lets current build. When the external trip comparator reports that the level is reached, the block switches the bridge into a decay state for a fixed number of clock cycles. It then drives again. After every drive start, the comparator is ignored for a blanking window so that switching spikes cannot cause a false trip.

During decay the switches that carry the recirculating current are driven on, which is synchronous rectification. Either both low-side switches are on (slow decay) or the opposite diagonal is on (fast decay). A zero-current detect input switches rectification off for the rest of that decay so that the current cannot reverse. A one-cycle all-off gap separates any two different on-patterns. All inputs are plain level signals with no handshake: the comparator, the zero detect and the control bits are sampled on every clock, and the block cannot stall them.

Top module: `chop_bridge_ctrl`

## Requirements
- R1: After reset, or in the cycle after `en_i` is low or `disable_i` is high, all four gate outputs are low. When enable returns (with `disable_i` low), one all-off cycle comes first and the drive state follows.
- R2: In the drive state the gate vector {hs_a_o, ls_a_o, hs_b_o, ls_b_o} is 4'b1001 when the direction is 0 and 4'b0110 when the direction is 1.
- R3: The trip input is ignored during the first BLANK_CYCLES cycles of every drive period, so a trip held high gives exactly BLANK_CYCLES+1 drive cycles.
- R4: A trip seen after blanking ends the drive state. Exactly one all-off cycle follows, then decay.
- R5: Decay lasts exactly OFF_CYCLES cycles. One all-off cycle follows, and then a new drive period starts with a fresh blanking window.
- R6: In slow decay (mode 0) with rectification active, the gate vector is 4'b0101 (both low-side switches on).
- R7: In fast decay (mode 1) with rectification active, the opposite diagonal is on: 4'b0110 for direction 0 and 4'b1001 for direction 1.
- R8: The decay mode is sampled once, on the cycle that enters decay. A change of `fast_decay_i` during decay has no effect until the next decay.
- R9: When `zero_i` is high in a decay cycle, all gates are low from the next cycle until that decay ends.
- R10: Two different non-zero gate vectors are always separated by at least one all-off cycle, and the high-side and low-side switches of the same leg are never on together.
- R11: A change of `dir_i` during drive causes one all-off cycle, then a drive in the new direction with a fresh blanking window. During decay the direction latched at drive time is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_i | input | 1 | Drive direction select |
| en_i | input | 1 | Enable / PWM gate; low forces idle |
| fast_decay_i | input | 1 | Decay mode: 1 fast, 0 slow |
| trip_i | input | 1 | Current trip comparator output |
| zero_i | input | 1 | Zero-current detect |
| disable_i | input | 1 | Global output disable; high forces idle |
| hs_a_o | output | 1 | High-side switch enable, leg A |
| ls_a_o | output | 1 | Low-side switch enable, leg A |
| hs_b_o | output | 1 | High-side switch enable, leg B |
| ls_b_o | output | 1 | Low-side switch enable, leg B |

## Verification
Some properties are checked on every cycle by the assertions:
- no leg ever shorted;
- an all-off gap between any two different on-patterns;
- forced idle when the block is disabled;
- trip ignored while blanked;
- decay always leaving on timer expiry;
- rectification switched off after zero detect.

Other behaviour needs the bench's scenarios:
- the exact cycle counts of blanking and off-time;
- the pattern chosen for each mode and direction;
- the decay mode held fixed through a decay;
- a trip pulse during blanking being dropped;
- rectification staying off for the rest of the decay;
- restart after disable.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GAP_DRV = 3'd1,
    ST_DRIVE   = 3'd2,
    ST_GAP_OFF = 3'd3,
    ST_DECAY   = 3'd4
  } chop_state_e;

  localparam int unsigned LEG_A = 0;
  localparam int unsigned LEG_B = 1;
  localparam int unsigned NUM_LEGS = 2;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  p_timer_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYCLES   = 3000,
  parameter int unsigned BLANK_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic en_i,
  input  logic fast_decay_i,
  input  logic trip_i,
  input  logic zero_i,
  input  logic disable_i,
  output logic [NUM_LEGS-1:0] hi_req,
  output logic [NUM_LEGS-1:0] lo_req
);
  localparam int unsigned MAXC = (OFF_CYCLES > BLANK_CYCLES) ? OFF_CYCLES : BLANK_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] OFF_LOAD   = CW'(OFF_CYCLES - 1);
  localparam logic [CW-1:0] BLANK_LOAD = CW'(BLANK_CYCLES);

  chop_state_e state_q, state_d;
  logic dir_q, fast_q, sr_q;
  logic tmr_load, tmr_dec, tmr_done;
  logic [CW-1:0] tmr_val;
  logic run_ok;

  assign run_ok = en_i && !disable_i;

  chop_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .done     (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = BLANK_LOAD;
    tmr_dec  = 1'b0;
    if (!run_ok) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:    state_d = ST_GAP_DRV;
        ST_GAP_DRV: begin
          state_d  = ST_DRIVE;
          tmr_load = 1'b1;
          tmr_val  = BLANK_LOAD;
        end
        ST_DRIVE: begin
          tmr_dec = 1'b1;
          if (dir_i != dir_q)          state_d = ST_GAP_DRV;
          else if (trip_i && tmr_done) state_d = ST_GAP_OFF;
        end
        ST_GAP_OFF: begin
          state_d  = ST_DECAY;
          tmr_load = 1'b1;
          tmr_val  = OFF_LOAD;
        end
        ST_DECAY: begin
          tmr_dec = 1'b1;
          if (tmr_done) state_d = ST_GAP_DRV;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      fast_q  <= 1'b0;
      sr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_GAP_DRV && run_ok) dir_q <= dir_i;
      if (state_q == ST_GAP_OFF && run_ok) begin
        fast_q <= fast_decay_i;
        sr_q   <= 1'b1;
      end else if (state_q == ST_DECAY && zero_i) begin
        sr_q <= 1'b0;
      end
    end
  end

  // Switch requests from registered state only; index 0 = leg A, 1 = leg B
  always_comb begin
    hi_req = '0;
    lo_req = '0;
    if (state_q == ST_DRIVE) begin
      hi_req[LEG_A] = !dir_q;
      lo_req[LEG_B] = !dir_q;
      hi_req[LEG_B] = dir_q;
      lo_req[LEG_A] = dir_q;
    end else if (state_q == ST_DECAY && sr_q) begin
      if (fast_q) begin
        hi_req[LEG_A] = dir_q;
        lo_req[LEG_B] = dir_q;
        hi_req[LEG_B] = !dir_q;
        lo_req[LEG_A] = !dir_q;
      end else begin
        lo_req = '1;
      end
    end
  end

  p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRIVE && !tmr_done && run_ok && dir_i == dir_q) |=> state_q == ST_DRIVE);
  p_trip_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRIVE && tmr_done && trip_i && run_ok && dir_i == dir_q) |=> state_q == ST_GAP_OFF);
  p_decay_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECAY && tmr_done && run_ok) |=> state_q == ST_GAP_DRV);
  p_mode_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECAY && $past(state_q) == ST_DECAY) |-> $stable(fast_q));
  p_zero_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECAY && zero_i) |=> (hi_req == '0 && lo_req == '0));
endmodule

// File: rtl/chop_leg.sv
module chop_leg (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_req,
  input  logic lo_req,
  output logic hi_on,
  output logic lo_on
);
  // Interlock: a conflicting request turns both switches of the leg off
  assign hi_on = hi_req && !lo_req;
  assign lo_on = lo_req && !hi_req;

  p_leg_req_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_req && lo_req));
endmodule

// File: rtl/chop_bridge_ctrl.sv
module chop_bridge_ctrl
  import chop_pkg::*;
#(
  parameter int unsigned OFF_CYCLES   = 3000,
  parameter int unsigned BLANK_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic en_i,
  input  logic fast_decay_i,
  input  logic trip_i,
  input  logic zero_i,
  input  logic disable_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o
);
  logic [NUM_LEGS-1:0] hi_req, lo_req, hi_on, lo_on;
  logic [3:0] gates;

  chop_fsm #(.OFF_CYCLES(OFF_CYCLES), .BLANK_CYCLES(BLANK_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_i        (dir_i),
    .en_i         (en_i),
    .fast_decay_i (fast_decay_i),
    .trip_i       (trip_i),
    .zero_i       (zero_i),
    .disable_i    (disable_i),
    .hi_req       (hi_req),
    .lo_req       (lo_req)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    chop_leg u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .hi_req (hi_req[g]),
      .lo_req (lo_req[g]),
      .hi_on  (hi_on[g]),
      .lo_on  (lo_on[g])
    );
  end

  assign hs_a_o = hi_on[LEG_A];
  assign ls_a_o = lo_on[LEG_A];
  assign hs_b_o = hi_on[LEG_B];
  assign ls_b_o = lo_on[LEG_B];
  assign gates  = {hs_a_o, ls_a_o, hs_b_o, ls_b_o};

  p_leg_never_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a_o && ls_a_o) && !(hs_b_o && ls_b_o));
  p_dead_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gates != 4'b0000 && $past(gates) != 4'b0000) |-> gates == $past(gates));
  p_forced_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || disable_i) |=> gates == 4'b0000);
endmodule

// File: tb/sim_chop_bridge_ctrl.sv
module sim_chop_bridge_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_i = 0, en_i = 0, fast_decay_i = 0, trip_i = 0, zero_i = 0, disable_i = 0;
  logic hs_a_o, ls_a_o, hs_b_o, ls_b_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [3:0] g; string tag; } exp_t;
  exp_t q[$];
  exp_t cur;

  always #2.5 clk = ~clk;

  chop_bridge_ctrl #(.OFF_CYCLES(12), .BLANK_CYCLES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .en_i(en_i), .fast_decay_i(fast_decay_i),
    .trip_i(trip_i), .zero_i(zero_i), .disable_i(disable_i),
    .hs_a_o(hs_a_o), .ls_a_o(ls_a_o), .hs_b_o(hs_b_o), .ls_b_o(ls_b_o)
  );

  // Monitor: compares the gate vector {hs_a, ls_a, hs_b, ls_b} once per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if ({hs_a_o, ls_a_o, hs_b_o, ls_b_o} !== cur.g) begin
        errors++;
        $display("FAIL %s: gates=%b expected=%b at %0t", cur.tag,
                 {hs_a_o, ls_a_o, hs_b_o, ls_b_o}, cur.g, $time);
      end
    end
  end

  // Driver: one entry per clock edge, the vector expected just after that edge
  task automatic ticks(input logic [3:0] g, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      q.push_back('{g, tag});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    ticks(4'b0000, 2, "R1 reset idle");

    // slow decay, dir 0, trip held through blanking
    dir_i = 0; fast_decay_i = 0; trip_i = 1; en_i = 1;
    ticks(4'b0000, 1, "R1 enable gap");
    ticks(4'b1001, 4, "R3 blanked drive dir0");
    ticks(4'b0000, 1, "R4 gap after trip");
    ticks(4'b0101, 11, "R6 slow decay");
    trip_i = 0; fast_decay_i = 1;
    ticks(4'b0101, 1, "R8 mode held");
    ticks(4'b0000, 1, "R5 gap after off-time");
    ticks(4'b1001, 6, "R2 drive dir0");
    trip_i = 1;
    ticks(4'b0000, 1, "R4 gap after trip");
    ticks(4'b0110, 1, "R7 fast decay dir0");
    trip_i = 0;
    ticks(4'b0110, 11, "R7 fast decay dir0");
    ticks(4'b0000, 1, "R5 gap");
    ticks(4'b1001, 3, "R5 new drive");

    // direction change during drive
    dir_i = 1;
    ticks(4'b0000, 1, "R11 dir change gap");
    ticks(4'b0110, 2, "R11 drive dir1");
    trip_i = 1;
    ticks(4'b0110, 2, "R11 fresh blanking");
    ticks(4'b0000, 1, "R4 gap");
    ticks(4'b1001, 3, "R7 fast decay dir1");
    trip_i = 0; zero_i = 1;
    ticks(4'b0000, 1, "R9 zero cut");
    zero_i = 0;
    ticks(4'b0000, 8, "R9 rectification stays off");
    ticks(4'b0000, 1, "R5 gap");
    ticks(4'b0110, 2, "R2 drive dir1");

    // trip pulse inside blanking
    trip_i = 1;
    ticks(4'b0110, 1, "R3 pulse ignored");
    trip_i = 0;
    ticks(4'b0110, 3, "R3 drive continues");

    // global disable and enable low
    disable_i = 1;
    ticks(4'b0000, 2, "R1 disable");
    disable_i = 0;
    ticks(4'b0000, 1, "R1 restart gap");
    ticks(4'b0110, 2, "R1 restart drive");
    en_i = 0;
    ticks(4'b0000, 2, "R1 enable low");

    @(negedge clk);
    #1;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule